// File: doc/BRIEF.md
# Serial Transmitter with Occupancy-Counted Byte Queue

The block is the transmit half of an asynchronous serial port. A host pushes bytes through a one-cycle write strobe into a 16-deep byte queue. The queue's occupancy is always visible as a 5-bit count. When the serial side is idle and a baud tick arrives, the oldest byte is loaded into a shift register and sent on a single output line. Each frame is a start bit, eight data bits, a parity bit and a stop bit.

A transmit enable input gates the whole serial side. While it is low, the queue still accepts writes, but nothing is loaded and the line stays high. A threshold input sets the level for a "room available" flag. The flag rises whenever the occupancy is at or below the threshold. The host can drop the flag only after the occupancy has climbed above the threshold.

Bit timing comes from an external one-cycle baud enable. The block has no baud divider of its own.

Top module: `txq_tx`

## Requirements
- R1: After reset the occupancy count is 0, the room flag is 1 and the line is high. The count never exceeds 16.
- R2: A write accepted when the count is below 16 increments the count by one, one cycle later. Each load of a byte into the shift register decrements it by one.
- R3: A write while the count equals 16 is discarded. The count stays at 16 and that byte never appears on the line.
- R4: Bytes appear on the line in exactly the order in which they were accepted.
- R5: The line idles high. A frame is one low start bit, then 8 data bits least significant first, then the parity bit, then one high stop bit. Each bit lasts from one baud tick to the next.
- R6: When the parity select input is 0, the parity bit makes the total count of ones across data and parity even. When it is 1, that total is odd.
- R7: While transmit enable is 0, no byte is loaded and the count is unaffected by baud ticks. The line is high from the next cycle on, and writes are still accepted.
- R8: One cycle after any cycle in which count <= threshold, the room flag is 1. A clear request only takes effect when count > threshold; otherwise the flag stays at 1.
- R9: A load happens on a baud tick when enable is 1, the queue is non-empty, and the shifter is idle or sending its stop bit. The start bit appears on the line right after that tick.
- R10: A write accepted in the same cycle as a load leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmit enable |
| baud_tick | input | 1 | One-cycle bit-time enable |
| par_odd | input | 1 | Parity select: 0 even, 1 odd |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| trig_lvl | input | 5 | Room-flag threshold, 0 to 16 |
| room_clr | input | 1 | Request to clear the room flag |
| occ_count | output | 5 | Queue occupancy, 0 to 16 |
| room_flag | output | 1 | Room-available flag |
| txd | output | 1 | Serial output line |

## Verification
A read or write pointer out of step with the occupancy count shows at the line as a repeated, skipped or stale byte. This is seen in the first frame that follows the fault. A count error is visible on the count port one cycle after the offending write or load. It also appears as a room flag that disagrees with the threshold comparison one cycle later. A wrong shifter phase corrupts the frame being sent: the decoder in the bench reports a bad parity or stop bit within 11 baud ticks.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } tx_phase_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          nonempty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, wr_ok;

  assign full     = (cnt_q == CW'(DEPTH));
  assign wr_ok    = push & ~full;
  assign nonempty = (cnt_q != '0);
  assign count    = cnt_q;
  assign pop_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_ok) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)   rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    unique case ({wr_ok, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_ok && (wp_q == PW'(i))) mem[i] <= push_data;
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q)));
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/txq_framer.sv
module txq_framer #(
  parameter int DW  = 8,
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tx_en,
  input  logic          baud_tick,
  input  logic          par_odd,
  input  logic          avail,
  input  logic [DW-1:0] pop_data,
  output logic          pop,
  output logic          txd
);
  import txq_pkg::*;

  tx_phase_e     ph_q, ph_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          par_q, par_d;
  logic          txd_q, txd_d;
  logic          load;

  assign load = tx_en && baud_tick && avail && (ph_q == PH_IDLE || ph_q == PH_STOP);
  assign pop  = load;
  assign txd  = txd_q;

  always_comb begin
    ph_d  = ph_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    par_d = par_q;
    txd_d = txd_q;
    if (!tx_en) begin
      ph_d  = PH_IDLE;
      txd_d = 1'b1;
      bit_d = '0;
    end else if (baud_tick) begin
      unique case (ph_q)
        PH_START: begin
          txd_d = sh_q[0];
          sh_d  = sh_q >> 1;
          bit_d = BW'(1);
          ph_d  = PH_DATA;
        end
        PH_DATA: begin
          if (bit_q == BW'(DW)) begin
            txd_d = par_q;
            ph_d  = PH_PAR;
          end else begin
            txd_d = sh_q[0];
            sh_d  = sh_q >> 1;
            bit_d = bit_q + 1'b1;
          end
        end
        PH_PAR: begin
          txd_d = 1'b1;
          ph_d  = PH_STOP;
        end
        PH_STOP: begin
          txd_d = 1'b1;
          ph_d  = PH_IDLE;
        end
        default: begin
          txd_d = 1'b1;
          ph_d  = PH_IDLE;
        end
      endcase
      if (load) begin
        sh_d  = pop_data;
        par_d = (^pop_data) ^ par_odd;
        txd_d = 1'b0;
        bit_d = '0;
        ph_d  = PH_START;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      par_q <= 1'b0;
      txd_q <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      par_q <= par_d;
      txd_q <= txd_d;
    end
  end

  p_line_high_off_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !tx_en |=> txd_q);
  p_no_load_off_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !tx_en |-> !pop);
  p_load_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> baud_tick);
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |=> !txd_q);
  p_stable_between_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_en && !baud_tick) |=> $stable(txd_q));
endmodule

// File: rtl/txq_room_flag.sv
module txq_room_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  input  logic          clr,
  output logic          flag
);
  logic below, flag_q, flag_d;

  assign below  = (count <= trig);
  assign flag_d = below | (flag_q & ~clr);
  assign flag   = flag_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b1;
    else         flag_q <= flag_d;
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    below |=> flag_q);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/txq_tx.sv
module txq_tx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          baud_tick,
  input  logic          par_odd,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] trig_lvl,
  input  logic          room_clr,
  output logic [CW-1:0] occ_count,
  output logic          room_flag,
  output logic          txd
);
  logic [1:0]    rs_q;
  logic          rst_ni;
  logic          pop, avail;
  logic [DW-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  txq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_ni(rst_ni), .push(wr_en), .push_data(wr_data),
    .pop(pop), .pop_data(head), .count(occ_count), .nonempty(avail)
  );

  txq_framer #(.DW(DW)) u_framer (
    .clk(clk), .rst_ni(rst_ni), .tx_en(tx_en), .baud_tick(baud_tick),
    .par_odd(par_odd), .avail(avail), .pop_data(head), .pop(pop), .txd(txd)
  );

  txq_room_flag #(.CW(CW)) u_flag (
    .clk(clk), .rst_ni(rst_ni), .count(occ_count), .trig(trig_lvl),
    .clr(room_clr), .flag(room_flag)
  );

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && pop && occ_count != CW'(DEPTH)) |=> (occ_count == $past(occ_count)));
endmodule

// File: tb/txq_tx_tb.sv
module txq_tx_tb;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;

  logic       clk, rst_n, tx_en, baud_tick, par_odd, wr_en, room_clr;
  logic [7:0] wr_data;
  logic [4:0] trig_lvl, occ_count;
  logic       room_flag, txd;

  txq_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .par_odd(par_odd), .wr_en(wr_en), .wr_data(wr_data), .trig_lvl(trig_lvl),
    .room_clr(room_clr), .occ_count(occ_count), .room_flag(room_flag), .txd(txd)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit auto_tick = 1, force_tick = 0;
  int div = 0;
  logic [7:0] exp_mem [512];
  int exp_n = 0, rx_n = 0, mcnt = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] d, input logic clr);
    @(negedge clk);
    wr_en     = we;
    wr_data   = d;
    room_clr  = clr;
    baud_tick = force_tick | (auto_tick && (div == DIV - 1));
    div       = (div + 1) % DIV;
  endtask

  // Frame decoder driven by the bench's own knowledge of tick timing
  logic tick_seen;
  int   ph = 0;
  logic [7:0] rx_byte;
  always @(posedge clk) tick_seen <= baud_tick;
  always @(negedge clk) begin
    if (rst_n && tick_seen) begin
      if (ph == 0) begin
        if (txd == 1'b0) ph = 1;
      end else if (ph <= 8) begin
        rx_byte[ph-1] = txd;
        ph++;
      end else if (ph == 9) begin
        chk(txd == ((^rx_byte) ^ par_odd), "R6 parity bit", txd, (^rx_byte) ^ par_odd);
        ph++;
      end else begin
        chk(txd == 1'b1, "R5 stop bit", txd, 1);
        chk(rx_byte == exp_mem[rx_n], "R4 byte order", rx_byte, exp_mem[rx_n]);
        rx_n++;
        ph = 0;
      end
    end
  end

  task automatic drain();
    tx_en = 1'b1;
    for (int k = 0; k < 4000 && occ_count != 0; k++) cyc(0, 8'h00, 0);
    chk(occ_count == 0, "R2 count drains to zero", occ_count, 0);
    for (int k = 0; k < 12*DIV + 4; k++) cyc(0, 8'h00, 0);
    tx_en = 1'b0;
    cyc(0, 8'h00, 0);
    cyc(0, 8'h00, 0);
    mcnt = 0;
    chk(rx_n == exp_n, "R4 frames received", rx_n, exp_n);
    chk(txd == 1'b1, "R5 line idles high", txd, 1);
    chk(room_flag == 1'b1, "R8 flag set when empty", room_flag, 1);
  endtask

  initial begin
    rst_n = 0; tx_en = 0; baud_tick = 0; par_odd = 0; wr_en = 0;
    wr_data = 0; room_clr = 0; trig_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) cyc(0, 8'h00, 0);
    chk(occ_count == 0, "R1 reset count", occ_count, 0);
    chk(room_flag == 1, "R1 reset flag", room_flag, 1);
    chk(txd == 1, "R1 reset line", txd, 1);

    for (int t = 0; t <= 16; t++) begin
      trig_lvl = 5'(t);
      par_odd  = t[0];
      cyc(0, 8'h00, 1);
      cyc(0, 8'h00, 0);
      chk(room_flag == 1, "R8 clear ignored at count 0", room_flag, 1);
      for (int c = 1; c <= 18; c++) begin
        logic [7:0] d;
        d = 8'((t*37 + c*11 + (c << 5)) & 8'hFF);
        cyc(1, d, 0);
        if (mcnt < 16) begin
          exp_mem[exp_n] = d;
          exp_n++;
          mcnt++;
        end
        cyc(0, 8'h00, 1);
        cyc(0, 8'h00, 0);
        if (c > 16) chk(occ_count == 16, "R3 full write dropped", occ_count, 16);
        else        chk(occ_count == 5'(mcnt), "R2 count after write", occ_count, mcnt);
        chk(room_flag == (mcnt <= t), "R8 flag vs threshold", room_flag, int'(mcnt <= t));
      end
      if (t == 0) begin
        for (int k = 0; k < 40; k++) begin
          cyc(0, 8'h00, 0);
          chk(txd == 1 && occ_count == 16, "R7 disabled holds", txd, 1);
        end
      end
      drain();
    end

    // Same-cycle write and load
    auto_tick = 0;
    par_odd = 0;
    trig_lvl = 5'd0;
    for (int k = 0; k < 3; k++) begin
      cyc(1, 8'(8'hA0 + k), 0);
      exp_mem[exp_n] = 8'(8'hA0 + k);
      exp_n++;
    end
    tx_en = 1'b1;
    cyc(0, 8'h00, 0);
    cyc(0, 8'h00, 0);
    chk(occ_count == 3 && txd == 1, "R9 no load without tick", occ_count, 3);
    force_tick = 1;
    cyc(1, 8'h5C, 0);
    exp_mem[exp_n] = 8'h5C;
    exp_n++;
    force_tick = 0;
    cyc(0, 8'h00, 0);
    chk(occ_count == 3, "R10 write plus load keeps count", occ_count, 3);
    chk(txd == 0, "R9 start bit after tick", txd, 0);
    div = 0;
    auto_tick = 1;
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule